// File: doc/BRIEF.md
# Timer Input Capture Unit

This block is a single-channel input-capture peripheral. An external event pin is brought into the clock domain through a two-stage synchronizer, and an edge detector compares each synchronized sample with the one before it. A 4-bit mode field decides which edges count. It can count every falling edge, every rising edge, or every 4th or 16th rising edge through a small prescaler counter. On each qualifying event the block copies a 16-bit timer value into its capture register. The value comes from one of two free-running timer inputs, chosen by a select bit.

Each capture sets a sticky interrupt flag. The flag stays set until software pulses the clear strobe. A capture that arrives before software has read the previous one simply replaces it.

The prescaler count is zeroed only while the mode field holds a non-capture code. A direct switch between two capture modes therefore keeps the old count, and it raises the flag. Software that wants a clean start writes the off code for at least one cycle before the new mode.

Top module: `evt_capture`

## Requirements
- R1: After reset the capture register reads 0 and the flag reads 0.
- R2: In mode 4'b0100 each falling edge of the pin is a capture event. A pin change driven before clock edge k is loaded into the capture register at edge k+2, so it is visible 3 clocks after the pin change.
- R3: In mode 4'b0101 each rising edge of the pin is a capture event, and falling edges do nothing.
- R4: In mode 4'b0110 every 4th rising edge is a capture event. The counter advances on each rising edge, fires when it has reached 3, and then wraps to 0.
- R5: In mode 4'b0111 every 16th rising edge is a capture event. The counter fires when it has reached 15.
- R6: A capture loads timer A when the select input is 0 and timer B when it is 1. The value taken is the one present during the cycle before the loading edge.
- R7: Every capture sets the flag. The flag stays set until a one-cycle clear strobe, after which it reads 0 from the next cycle.
- R8: When the clear strobe and a capture fall in the same cycle, the capture wins and the flag stays 1.
- R9: A new capture overwrites the capture register even while the flag is still set, and no other indication is given.
- R10: Mode 4'b0000 and every code outside 4'b0100..4'b0111 cause no capture. They leave the register and the flag unchanged and hold the prescaler count at 0.
- R11: A direct change from one capture mode to a different capture mode keeps the prescaler count and sets the flag one cycle later without loading the register. A prescaled event fires on the first rising edge that finds the count at or above the new ratio minus one.
- R12: Passing through mode 4'b0000 for at least one cycle before entering a capture mode sets no flag, and the full new ratio of rising edges is then needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 4 | Event mode code |
| tsel_i | input | 1 | Timer source select (0 = timer A, 1 = timer B) |
| pin_i | input | 1 | Asynchronous event pin |
| tmr_a_i | input | 16 | Timer A value |
| tmr_b_i | input | 16 | Timer B value |
| flag_clr_i | input | 1 | Flag clear strobe, one cycle |
| cap_o | output | 16 | Capture register |
| flag_o | output | 1 | Sticky capture flag |

## Verification
A pin change becomes a capture at the third clock edge after it is driven. A mode-change flag appears at the first edge after the new mode is applied. A clear strobe takes effect at the edge it is held across. The bench drives inputs on falling clock edges and runs a behavioural model that tracks the synchronizer and the prescaler count as plain integers. Outputs are compared with that model at every falling edge. The directed checks wait a known number of falling edges after each stimulus: one early sample proves the capture has not yet happened, and the next proves it has.

// File: rtl/evt_capture_pkg.sv
package evt_capture_pkg;

    localparam logic [3:0] MODE_OFF    = 4'b0000;
    localparam logic [3:0] MODE_FALL   = 4'b0100;
    localparam logic [3:0] MODE_RISE   = 4'b0101;
    localparam logic [3:0] MODE_RISE_A = 4'b0110;
    localparam logic [3:0] MODE_RISE_B = 4'b0111;

    function automatic logic is_capture(input logic [3:0] m);
        return (m[3:2] == 2'b01);
    endfunction

    function automatic logic is_rising(input logic [3:0] m);
        return (m == MODE_RISE) || (m == MODE_RISE_A) || (m == MODE_RISE_B);
    endfunction

endpackage

// File: rtl/evt_sync_edge.sv
module evt_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[STAGES-2:0], pin_i};
        st_d.prev = st_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o =  st_q.sh[STAGES-1] & ~st_q.prev;
    assign fall_o = ~st_q.sh[STAGES-1] &  st_q.prev;

    AST_RISE_NOT_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R3

    AST_FALL_NOT_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o); // R2

endmodule

// File: rtl/evt_prescaler.sv
module evt_prescaler
    import evt_capture_pkg::*;
#(
    parameter int DIV_A = 4,
    parameter int DIV_B = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] mode_i,
    input  logic       rise_i,
    input  logic       fall_i,
    output logic       event_o
);

    localparam int CNT_W = (DIV_B > 1) ? $clog2(DIV_B) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic    evt;

    function automatic logic [CNT_W-1:0] limit_of(input logic [3:0] m);
        case (m)
            MODE_RISE_A: limit_of = CNT_W'(DIV_A - 1);
            MODE_RISE_B: limit_of = CNT_W'(DIV_B - 1);
            default:     limit_of = '0;
        endcase
    endfunction

    always_comb begin
        st_d = st_q;
        evt  = 1'b0;
        if (mode_i == MODE_FALL) begin
            evt = fall_i;
        end else if (is_rising(mode_i)) begin
            if (rise_i) begin
                if (st_q.cnt >= limit_of(mode_i)) begin
                    evt      = 1'b1;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign event_o = evt;

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !is_capture(mode_i) |=> (st_q.cnt == '0)); // R10

    AST_IDLE_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        !is_capture(mode_i) |-> !event_o); // R10

    AST_PRESCALED_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (event_o && is_rising(mode_i)) |-> rise_i); // R4

    AST_WRAP_AFTER_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        (event_o && is_rising(mode_i)) |=> (st_q.cnt == '0)); // R5

endmodule

// File: rtl/evt_latch.sv
module evt_latch #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             event_i,
    input  logic             spur_i,
    input  logic             tsel_i,
    input  logic [TMR_W-1:0] tmr_a_i,
    input  logic [TMR_W-1:0] tmr_b_i,
    input  logic             clr_i,
    output logic [TMR_W-1:0] cap_o,
    output logic             flag_o
);

    typedef struct packed {
        logic [TMR_W-1:0] cap;
        logic             flag;
    } lat_st_t;

    lat_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (event_i) begin
            st_d.cap = tsel_i ? tmr_b_i : tmr_a_i;
        end
        if (event_i || spur_i) begin
            st_d.flag = 1'b1;
        end else if (clr_i) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_o  = st_q.cap;
    assign flag_o = st_q.flag;

    AST_FLAG_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        event_i |=> flag_o); // R7

    AST_CAPTURE_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (event_i && clr_i) |=> flag_o); // R8

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !event_i && !spur_i) |=> !flag_o); // R7

    AST_CAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !event_i |=> $stable(cap_o)); // R9

    AST_SRC_A: assert property (@(posedge clk) disable iff (!rst_n)
        (event_i && !tsel_i) |=> (cap_o == $past(tmr_a_i))); // R6

    AST_SRC_B: assert property (@(posedge clk) disable iff (!rst_n)
        (event_i && tsel_i) |=> (cap_o == $past(tmr_b_i))); // R6

endmodule

// File: rtl/evt_capture.sv
module evt_capture
    import evt_capture_pkg::*;
#(
    parameter int TMR_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_A       = 4,
    parameter int DIV_B       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       mode_i,
    input  logic             tsel_i,
    input  logic             pin_i,
    input  logic [TMR_W-1:0] tmr_a_i,
    input  logic [TMR_W-1:0] tmr_b_i,
    input  logic             flag_clr_i,
    output logic [TMR_W-1:0] cap_o,
    output logic             flag_o
);

    typedef struct packed {
        logic [3:0] mode;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    rise, fall, evt, spur;

    always_comb begin
        st_d      = st_q;
        st_d.mode = mode_i;
        spur      = is_capture(mode_i) && is_capture(st_q.mode) && (mode_i != st_q.mode);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_OFF};
        else        st_q <= st_d;
    end

    evt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    evt_prescaler #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_i),
        .rise_i  (rise),
        .fall_i  (fall),
        .event_o (evt)
    );

    evt_latch #(.TMR_W(TMR_W)) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .event_i (evt),
        .spur_i  (spur),
        .tsel_i  (tsel_i),
        .tmr_a_i (tmr_a_i),
        .tmr_b_i (tmr_b_i),
        .clr_i   (flag_clr_i),
        .cap_o   (cap_o),
        .flag_o  (flag_o)
    );

    AST_SWITCH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        spur |=> flag_o); // R11

    AST_SWITCH_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (spur && !evt) |=> $stable(cap_o)); // R11

    AST_FROM_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_OFF && !evt && flag_clr_i) |=> !flag_o); // R12

endmodule

// File: tb/evt_capture_bench.sv
module evt_capture_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mode = 4'b0000;
    logic        tsel = 1'b0;
    logic        pin = 1'b0;
    logic [15:0] ta = 16'h0000;
    logic [15:0] tb = 16'h0000;
    logic        clr = 1'b0;
    logic [15:0] cap;
    logic        flag;

    int    total = 0;
    int    bad = 0;
    int    cycles = 0;
    bit    cmp_en = 1'b0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    evt_capture u_evt_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode),
        .tsel_i     (tsel),
        .pin_i      (pin),
        .tmr_a_i    (ta),
        .tmr_b_i    (tb),
        .flag_clr_i (clr),
        .cap_o      (cap),
        .flag_o     (flag)
    );

    // behavioural reference model
    int m_s1, m_s2, m_prv, m_cnt, m_mprev, m_cap, m_flag;

    function automatic bit cap_code(input int m);
        return (m >= 4) && (m <= 7);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prv = 0; m_cnt = 0; m_mprev = 0; m_cap = 0; m_flag = 0;
        end else begin
            automatic bit r  = (m_s2 == 1) && (m_prv == 0);
            automatic bit f  = (m_s2 == 0) && (m_prv == 1);
            automatic bit ev = 1'b0;
            automatic int nc = m_cnt;
            automatic int md = int'(mode);
            automatic int ratio = (md == 6) ? 4 : ((md == 7) ? 16 : 1);
            automatic bit sp;
            if (md == 4) ev = f;
            else if (md >= 5 && md <= 7) begin
                if (r) begin
                    if (m_cnt >= ratio - 1) begin ev = 1'b1; nc = 0; end
                    else nc = m_cnt + 1;
                end
            end else nc = 0;
            sp = cap_code(md) && cap_code(m_mprev) && (md != m_mprev);
            if (ev) m_cap = tsel ? int'(tb) : int'(ta);
            if (ev || sp) m_flag = 1;
            else if (clr) m_flag = 0;
            m_prv = m_s2; m_s2 = m_s1; m_s1 = int'(pin);
            m_cnt = nc; m_mprev = md;
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (cmp_en) begin
            total++;
            if (int'(cap) != m_cap || int'(flag) != m_flag) begin
                bad++;
                $display("FAIL %s model: cap=%h exp=%h flag=%0d exp=%0d",
                         cur_req, cap, m_cap[15:0], flag, m_flag);
            end
        end
    end

    task automatic chk(input string req, input logic [15:0] exp_cap, input logic exp_flag);
        total++;
        if (cap !== exp_cap || flag !== exp_flag) begin
            bad++;
            $display("FAIL %s: cap=%h exp=%h flag=%b exp=%b", req, cap, exp_cap, flag, exp_flag);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse();
        pin = 1'b1; wait_n(2);
        pin = 1'b0; wait_n(3);
    endtask

    task automatic clear_flag();
        clr = 1'b1; wait_n(1);
        clr = 1'b0;
    endtask

    task automatic set_mode(input logic [3:0] m);
        mode = m; wait_n(1);
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        chk("R1", 16'h0000, 1'b0);
        cmp_en = 1'b1;

        // R2: falling edges and latency
        cur_req = "R2";
        ta = 16'h1234; tb = 16'hABCD;
        set_mode(4'b0100);
        pin = 1'b1; wait_n(4);
        chk("R2", 16'h0000, 1'b0);
        pin = 1'b0; wait_n(2);
        chk("R2", 16'h0000, 1'b0);
        wait_n(1);
        chk("R2", 16'h1234, 1'b1);

        // R7: sticky then cleared
        cur_req = "R7";
        wait_n(5);
        chk("R7", 16'h1234, 1'b1);
        clear_flag();
        chk("R7", 16'h1234, 1'b0);

        // R3 R6 R12: through off to rising, timer B
        cur_req = "R3";
        set_mode(4'b0000);
        set_mode(4'b0101);
        tsel = 1'b1;
        wait_n(2);
        chk("R12", 16'h1234, 1'b0);
        pin = 1'b1; wait_n(3);
        chk("R6", 16'hABCD, 1'b1);
        clear_flag();
        pin = 1'b0; wait_n(4);
        chk("R3", 16'hABCD, 1'b0);

        // R9: overwrite while flag set
        cur_req = "R9";
        tb = 16'h5555;
        pulse();
        chk("R9", 16'h5555, 1'b1);
        tb = 16'h6666;
        pulse();
        chk("R9", 16'h6666, 1'b1);

        // R8: clear and capture in the same cycle
        cur_req = "R8";
        tb = 16'h7777;
        pin = 1'b1; wait_n(2);
        clr = 1'b1; wait_n(1);
        clr = 1'b0;
        chk("R8", 16'h7777, 1'b1);
        pin = 1'b0; wait_n(3);

        // R4: every 4th rising edge, timer A
        cur_req = "R4";
        set_mode(4'b0000);
        set_mode(4'b0110);
        tsel = 1'b0;
        clear_flag();
        ta = 16'h4444;
        for (int i = 0; i < 3; i++) pulse();
        chk("R4", 16'h7777, 1'b0);
        pulse();
        chk("R4", 16'h4444, 1'b1);
        clear_flag();
        ta = 16'h4545;
        for (int i = 0; i < 3; i++) pulse();
        chk("R4", 16'h4444, 1'b0);
        pulse();
        chk("R4", 16'h4545, 1'b1);

        // R5: every 16th rising edge
        cur_req = "R5";
        set_mode(4'b0000);
        set_mode(4'b0111);
        clear_flag();
        ta = 16'h1616;
        for (int i = 0; i < 15; i++) pulse();
        chk("R5", 16'h4545, 1'b0);
        pulse();
        chk("R5", 16'h1616, 1'b1);

        // R10: off and non-capture codes
        cur_req = "R10";
        ta = 16'hDEAD;
        set_mode(4'b0000);
        for (int i = 0; i < 3; i++) pulse();
        chk("R10", 16'h1616, 1'b1);
        set_mode(4'b1101);
        for (int i = 0; i < 3; i++) pulse();
        chk("R10", 16'h1616, 1'b1);

        // R12: count zeroed by passing through off
        cur_req = "R12";
        set_mode(4'b0000);
        set_mode(4'b0111);
        clear_flag();
        for (int i = 0; i < 5; i++) pulse();
        set_mode(4'b0000);
        set_mode(4'b0110);
        wait_n(1);
        chk("R12", 16'h1616, 1'b0);
        ta = 16'h1212;
        for (int i = 0; i < 3; i++) pulse();
        chk("R12", 16'h1616, 1'b0);
        pulse();
        chk("R12", 16'h1212, 1'b1);

        // R11: direct switch keeps stale count and flags
        cur_req = "R11";
        set_mode(4'b0000);
        set_mode(4'b0111);
        clear_flag();
        for (int i = 0; i < 9; i++) pulse();
        chk("R11", 16'h1212, 1'b0);
        mode = 4'b0110; wait_n(1);
        chk("R11", 16'h1212, 1'b1);
        clear_flag();
        chk("R11", 16'h1212, 1'b0);
        ta = 16'h0B0B;
        pulse();
        chk("R11", 16'h0B0B, 1'b1);

        // mixed traffic against the model
        cur_req = "R11 mixed";
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            ta = ta + 16'd1;
            tb = tb + 16'd3;
            if ($urandom_range(0, 2) == 0) pin = ~pin;
            clr = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 31) == 0) tsel = ~tsel;
            if ($urandom_range(0, 63) == 0) begin
                case ($urandom_range(0, 5))
                    0: mode = 4'b0000;
                    1: mode = 4'b0100;
                    2: mode = 4'b0101;
                    3: mode = 4'b0110;
                    4: mode = 4'b0111;
                    default: mode = 4'b1101;
                endcase
            end
        end
        clr = 1'b0;
        wait_n(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        bad++;
        total++;
        $display("FAIL watchdog %s: cycles=%0d exp=below 100000", cur_req, cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule